// File: doc/BRIEF.md
# Multi-Channel Peripheral DMA Engine with Buffer Chaining

This block moves single words between peripheral data ports and system memory without the processor. It owns one bus master port and issues one simple word read or write at a time. Every channel has a current memory pointer and word count, plus a queued pointer and count. Software can place the next buffer in the queue while the current one is still running, so the block moves from one buffer to the next without waiting for the processor.

Peripherals hold a per-channel request line high while they want service. The engine picks a channel with a fixed-priority arbiter, which favours the higher channel index. It tells the peripheral which channel is being served through `xfer_ch`. For a receive channel it writes the peripheral's word into memory. For a transmit channel it reads memory and hands the word to the peripheral. Each transfer ends with a one-cycle done pulse on that channel's line. By default the channel layout puts ten transmit channels at the bottom and eleven receive channels above them. A shared-direction channel sits at the top, so every receive channel outranks every transmit channel.

Top module: `pdma_engine`

## Requirements
- R1: After reset, `m_req`, `xfer_busy` and `per_done` are low, and every bit of `ch_end` and `ch_full` is high, because all counts are zero. Every channel starts disabled, and the shared channel starts as a transmit channel.
- R2: The register port has five field codes on `reg_sel`: 0 current pointer, 1 current count, 2 queued pointer, 3 queued count, 4 control. A channel with pointer P and count N that is enabled and requesting performs N transfers, at addresses P, P+4, P+8 and so on. The step is 4 bytes by default.
- R3: A receive channel issues memory writes (`m_we`=1) carrying `per_rx_word`. A transmit channel issues reads (`m_we`=0), and the word read from memory appears on `per_tx_word` while that channel's done pulse is high.
- R4: When several channels are eligible in the same cycle, the highest index is served first. By default indices 0 to 9 are transmit, 10 to 20 are receive, and 21 is the shared channel.
- R5: Only one transaction is outstanding. `m_req` stays high with a stable address and direction until `m_ack`, and it is low in the cycle after the ack.
- R6: `per_done` is one-hot and pulses for exactly one cycle, in the cycle after the ack of that channel's transaction.
- R7: When the current count reaches zero and the queued count is nonzero, the queued pointer and count become current and the queued count clears. This also happens when software writes a queued buffer while the current count is already zero.
- R8: A channel whose current and queued counts are both zero is never served, even while it requests. `ch_end` flags a zero current count. `ch_full` flags that both counts are zero.
- R9: Control bit 0 enables a channel. Control bit 1 disables it, and bit 1 wins if both are set. A disabled channel is never granted, keeps its pointer and counts, and resumes where it stopped once it is enabled again.
- R10: A write to the current count while that channel's transaction is in flight is held back. It replaces the count when the ack arrives, and the pointer still advances.
- R11: Control bit 2 selects receive (1) or transmit (0) on the shared channel only. On the other channels it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_ch | input | CHW | Channel addressed by the write |
| reg_sel | input | 3 | Field code (0 ptr, 1 count, 2 queued ptr, 3 queued count, 4 control) |
| reg_wdata | input | AW | Write data |
| per_req | input | NCH | Per-channel service request, level |
| per_done | output | NCH | Per-channel one-cycle transfer-done pulse |
| per_rx_word | input | DW | Word from the peripheral selected by `xfer_ch` |
| per_tx_word | output | DW | Word read from memory for a transmit channel |
| xfer_ch | output | CHW | Channel being served |
| xfer_busy | output | 1 | A transfer is in progress |
| ch_end | output | NCH | Current count is zero |
| ch_full | output | NCH | Current and queued counts are both zero |
| m_req | output | 1 | Master transaction request |
| m_we | output | 1 | Master write (1) or read (0) |
| m_addr | output | AW | Master byte address |
| m_wdata | output | DW | Master write data |
| m_rdata | input | DW | Master read data |
| m_ack | input | 1 | Master transaction complete |

## Verification
Single-channel runs in each direction, with zero and nonzero memory latency, show that the addresses advance, the direction is right and the data lands where it should. A run that raises four requests at once, spread across transmit, receive and shared channels, separates a fixed-priority order from first-come or rotating orders. Queued-buffer runs, one that chains mid-stream and one that reloads from an empty current buffer, separate automatic chaining from stopping. A disable after one transfer, and a count write during a slow transaction, separate held state and deferred writes from immediate ones.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
   typedef enum logic [2:0] {
      FLD_PTR  = 3'd0,
      FLD_CNT  = 3'd1,
      FLD_NPTR = 3'd2,
      FLD_NCNT = 3'd3,
      FLD_CTL  = 3'd4
   } fld_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_BUS,
      ST_DONE
   } st_e;

   localparam int CTL_EN_BIT  = 0;
   localparam int CTL_DIS_BIT = 1;
   localparam int CTL_RX_BIT  = 2;
endpackage

// File: rtl/pdma_chan.sv
module pdma_chan
   import pdma_pkg::*;
#(
   parameter int AW         = 32,
   parameter int CW         = 16,
   parameter int WORD_BYTES = 4,
   parameter bit FIXED_RX   = 1'b0,
   parameter bit SHARED     = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_ptr,
   input  logic          wr_cnt,
   input  logic          wr_nptr,
   input  logic          wr_ncnt,
   input  logic          wr_ctl,
   input  logic [AW-1:0] wdata,
   input  logic          inflight,
   input  logic          ack,
   output logic [AW-1:0] ptr,
   output logic          enabled,
   output logic          is_rx,
   output logic          at_end,
   output logic          drained
);
   localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

   logic [AW-1:0] ptr_q, ptr_d, nptr_q, nptr_d;
   logic [CW-1:0] cnt_q, cnt_d, ncnt_q, ncnt_d, pend_q, pend_d;
   logic          pv_q, pv_d, en_q, en_d;

   always_comb begin
      ptr_d  = ptr_q;
      cnt_d  = cnt_q;
      nptr_d = nptr_q;
      ncnt_d = ncnt_q;
      pend_d = pend_q;
      pv_d   = pv_q;
      en_d   = en_q;
      if (ack) begin
         ptr_d = ptr_q + STEP;
         cnt_d = pv_q ? pend_q : (cnt_q - CW'(1));
         pv_d  = 1'b0;
      end
      if (wr_ptr) ptr_d = wdata;
      if (wr_cnt) begin
         if (inflight && !ack) begin
            pv_d   = 1'b1;
            pend_d = wdata[CW-1:0];
         end else begin
            cnt_d = wdata[CW-1:0];
            pv_d  = 1'b0;
         end
      end
      if (wr_nptr) nptr_d = wdata;
      if (wr_ncnt) ncnt_d = wdata[CW-1:0];
      if (wr_ctl) begin
         if (wdata[CTL_DIS_BIT])     en_d = 1'b0;
         else if (wdata[CTL_EN_BIT]) en_d = 1'b1;
      end
      if (cnt_d == '0 && ncnt_d != '0) begin
         ptr_d  = nptr_d;
         cnt_d  = ncnt_d;
         ncnt_d = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         cnt_q  <= '0;
         nptr_q <= '0;
         ncnt_q <= '0;
         pend_q <= '0;
         pv_q   <= 1'b0;
         en_q   <= 1'b0;
      end else begin
         ptr_q  <= ptr_d;
         cnt_q  <= cnt_d;
         nptr_q <= nptr_d;
         ncnt_q <= ncnt_d;
         pend_q <= pend_d;
         pv_q   <= pv_d;
         en_q   <= en_d;
      end
   end

   generate
      if (SHARED) begin : g_shared
         logic dir_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      dir_q <= 1'b0;
            else if (wr_ctl) dir_q <= wdata[CTL_RX_BIT];
         end
         assign is_rx = dir_q;
      end else begin : g_fixed
         assign is_rx = FIXED_RX;
      end
   endgenerate

   assign ptr     = ptr_q;
   assign enabled = en_q;
   assign at_end  = (cnt_q == '0);
   assign drained = (cnt_q == '0) && (ncnt_q == '0);
endmodule

// File: rtl/pdma_pick.sv
module pdma_pick #(
   parameter  int N  = 22,
   localparam int IW = $clog2(N)
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (req[i]) idx = IW'(i);
      end
   end
   assign any = |req;
endmodule

// File: rtl/pdma_engine.sv
module pdma_engine
   import pdma_pkg::*;
#(
   parameter  int             NCH        = 22,
   parameter  int             AW         = 32,
   parameter  int             DW         = 32,
   parameter  int             CW         = 16,
   parameter  int             WORD_BYTES = 4,
   parameter  logic [NCH-1:0] RX_MASK    = 22'h1FFC00,
   parameter  logic [NCH-1:0] BIDIR_MASK = 22'h200000,
   localparam int             CHW        = $clog2(NCH)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reg_we,
   input  logic [CHW-1:0]  reg_ch,
   input  logic [2:0]      reg_sel,
   input  logic [AW-1:0]   reg_wdata,
   input  logic [NCH-1:0]  per_req,
   output logic [NCH-1:0]  per_done,
   input  logic [DW-1:0]   per_rx_word,
   output logic [DW-1:0]   per_tx_word,
   output logic [CHW-1:0]  xfer_ch,
   output logic            xfer_busy,
   output logic [NCH-1:0]  ch_end,
   output logic [NCH-1:0]  ch_full,
   output logic            m_req,
   output logic            m_we,
   output logic [AW-1:0]   m_addr,
   output logic [DW-1:0]   m_wdata,
   input  logic [DW-1:0]   m_rdata,
   input  logic            m_ack
);
   generate
      if (NCH < 2) begin : g_bad_nch
         $error("pdma_engine: at least two channels are required");
      end
      if (CW < 2 || CW > AW) begin : g_bad_cw
         $error("pdma_engine: counter width must lie between 2 and the address width");
      end
      if (WORD_BYTES < 1 || (WORD_BYTES & (WORD_BYTES - 1)) != 0) begin : g_bad_step
         $error("pdma_engine: word size must be a power of two");
      end
      for (genvar k = 0; k < NCH - 1; k++) begin : g_order
         if (BIDIR_MASK[k]) begin : g_bd
            $error("pdma_engine: the shared channel must be the top index");
         end
         if (RX_MASK[k] && !RX_MASK[k+1] && !BIDIR_MASK[k+1]) begin : g_rx
            $error("pdma_engine: a transmit channel may not rank above a receive channel");
         end
      end
   endgenerate

   logic [AW-1:0]  ptr_a [NCH];
   logic [NCH-1:0] en_v, rx_v, end_v, full_v, elig;
   logic           pick_any;
   logic [CHW-1:0] pick_idx;

   st_e            st;
   logic [CHW-1:0] cur;
   logic [AW-1:0]  addr_q;
   logic           we_q;
   logic [DW-1:0]  txw_q;

   logic hit;
   assign hit = reg_we;

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic sel_me;
      assign sel_me = hit && (reg_ch == CHW'(i));
      pdma_chan #(
         .AW(AW), .CW(CW), .WORD_BYTES(WORD_BYTES),
         .FIXED_RX(RX_MASK[i]), .SHARED(BIDIR_MASK[i])
      ) u_ch (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_ptr   (sel_me && (reg_sel == FLD_PTR)),
         .wr_cnt   (sel_me && (reg_sel == FLD_CNT)),
         .wr_nptr  (sel_me && (reg_sel == FLD_NPTR)),
         .wr_ncnt  (sel_me && (reg_sel == FLD_NCNT)),
         .wr_ctl   (sel_me && (reg_sel == FLD_CTL)),
         .wdata    (reg_wdata),
         .inflight ((st == ST_BUS) && (cur == CHW'(i))),
         .ack      ((st == ST_BUS) && m_ack && (cur == CHW'(i))),
         .ptr      (ptr_a[i]),
         .enabled  (en_v[i]),
         .is_rx    (rx_v[i]),
         .at_end   (end_v[i]),
         .drained  (full_v[i])
      );
   end

   assign elig = en_v & per_req & ~end_v;

   pdma_pick #(.N(NCH)) u_pick (
      .req (elig),
      .any (pick_any),
      .idx (pick_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         cur    <= '0;
         addr_q <= '0;
         we_q   <= 1'b0;
         txw_q  <= '0;
      end else begin
         unique case (st)
            ST_IDLE: if (pick_any) begin
               cur    <= pick_idx;
               addr_q <= ptr_a[pick_idx];
               we_q   <= rx_v[pick_idx];
               st     <= ST_BUS;
            end
            ST_BUS: if (m_ack) begin
               if (!we_q) txw_q <= m_rdata;
               st <= ST_DONE;
            end
            ST_DONE: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      per_done = '0;
      if (st == ST_DONE) per_done[cur] = 1'b1;
   end

   assign m_req       = (st == ST_BUS);
   assign m_we        = we_q;
   assign m_addr      = addr_q;
   assign m_wdata     = per_rx_word;
   assign per_tx_word = txw_q;
   assign xfer_ch     = cur;
   assign xfer_busy   = (st != ST_IDLE);
   assign ch_end      = end_v;
   assign ch_full     = full_v;
endmodule

// File: rtl/pdma_engine_chk.sv
module pdma_engine_chk #(
   parameter int NCH = 22,
   parameter int AW  = 32,
   parameter int CHW = 5
) (
   input logic           clk,
   input logic           rst_n,
   input logic           m_req,
   input logic           m_ack,
   input logic           m_we,
   input logic [AW-1:0]  m_addr,
   input logic [NCH-1:0] per_done,
   input logic [CHW-1:0] xfer_ch,
   input logic           xfer_busy,
   input logic [NCH-1:0] ch_end,
   input logic [NCH-1:0] elig,
   input logic [NCH-1:0] en_v
);
   logic [NCH-1:0] end_q, elig_q, en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         end_q  <= '1;
         elig_q <= '0;
         en_q   <= '0;
      end else begin
         end_q  <= ch_end;
         elig_q <= elig;
         en_q   <= en_v;
      end
   end

   a_r5_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (m_req && !m_ack) |=> (m_req && $stable(m_addr) && $stable(m_we)));

   a_r5_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (m_req && m_ack) |=> !m_req);

   a_r5_req_implies_busy: assert property (@(posedge clk) disable iff (!rst_n)
      m_req |-> xfer_busy);

   a_r6_done_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(per_done));

   a_r6_done_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (per_done != '0) |-> $past(m_req && m_ack));

   a_r4_highest_wins: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(m_req) |-> ((elig_q >> xfer_ch) == NCH'(1)));

   a_r8_grant_had_words: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(m_req) |-> !end_q[xfer_ch]);

   a_r9_grant_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(m_req) |-> en_q[xfer_ch]);
endmodule

bind pdma_engine pdma_engine_chk #(.NCH(NCH), .AW(AW), .CHW(CHW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .m_req     (m_req),
   .m_ack     (m_ack),
   .m_we      (m_we),
   .m_addr    (m_addr),
   .per_done  (per_done),
   .xfer_ch   (xfer_ch),
   .xfer_busy (xfer_busy),
   .ch_end    (ch_end),
   .elig      (elig),
   .en_v      (en_v)
);

// File: tb/pdma_engine_bench.sv
`timescale 1ns/1ps
module pdma_engine_bench;
   localparam int NCH = 22;
   localparam int AW  = 32;
   localparam int DW  = 32;
   localparam int CHW = 5;
   localparam logic [31:0] KEY = 32'hA5A5_0000;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           reg_we = 1'b0;
   logic [CHW-1:0] reg_ch = '0;
   logic [2:0]     reg_sel = '0;
   logic [AW-1:0]  reg_wdata = '0;
   logic [NCH-1:0] per_req = '0;
   logic [NCH-1:0] per_done;
   logic [DW-1:0]  per_rx_word;
   logic [DW-1:0]  per_tx_word;
   logic [CHW-1:0] xfer_ch;
   logic           xfer_busy;
   logic [NCH-1:0] ch_end, ch_full;
   logic           m_req, m_we;
   logic [AW-1:0]  m_addr;
   logic [DW-1:0]  m_wdata;
   logic [DW-1:0]  m_rdata = '0;
   logic           m_ack = 1'b0;

   always #2 clk = ~clk;

   assign per_rx_word = 32'h5A00_0000 | 32'(xfer_ch);

   pdma_engine u_pdma_engine (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_ch(reg_ch), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .per_req(per_req), .per_done(per_done),
      .per_rx_word(per_rx_word), .per_tx_word(per_tx_word), .xfer_ch(xfer_ch),
      .xfer_busy(xfer_busy), .ch_end(ch_end), .ch_full(ch_full), .m_req(m_req),
      .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ack(m_ack)
   );

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // memory model and transaction log
   logic [31:0] la [64];
   logic        lw [64];
   logic [31:0] ld [64];
   logic [4:0]  lc [64];
   int          ln = 0;
   int          mem_lat = 0;
   int          wait_c = 0;
   bit          was_ack = 1'b0;
   int          last_ack_cyc = -10;
   logic [31:0] hold_a = '0;
   int          r5_err = 0;
   int          r6_err = 0;

   always @(negedge clk) begin
      if (was_ack && m_req) r5_err++;
      was_ack = 1'b0;
      if (m_req && !m_ack) begin
         if (wait_c > 0 && m_addr != hold_a) r5_err++;
         hold_a = m_addr;
         if (wait_c >= mem_lat) begin
            m_ack   = 1'b1;
            m_rdata = m_addr ^ KEY;
            if (ln < 64) begin
               la[ln] = m_addr; lw[ln] = m_we; ld[ln] = m_wdata; lc[ln] = xfer_ch;
            end
            ln++;
            was_ack = 1'b1;
            last_ack_cyc = cyc;
            wait_c = 0;
         end else begin
            wait_c++;
         end
      end else begin
         m_ack = 1'b0;
      end
   end

   // done monitor
   int          dc [64];
   logic [31:0] dt [64];
   int          dn = 0;
   always @(negedge clk) begin
      if (per_done != '0) begin
         int idx;
         idx = 0;
         if ($countones(per_done) != 1) r6_err++;
         if (cyc != last_ack_cyc + 1) r6_err++;
         for (int i = 0; i < NCH; i++) if (per_done[i]) idx = i;
         if (dn < 64) begin dc[dn] = idx; dt[dn] = per_tx_word; end
         dn++;
      end
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic wr(input int ch, input logic [2:0] sel, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_ch = CHW'(ch); reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic setup(input int ch, input logic [31:0] p, input logic [31:0] n,
                        input logic [31:0] ctl);
      wr(ch, 3'd0, p);
      wr(ch, 3'd1, n);
      wr(ch, 4'd4, ctl);
   endtask

   task automatic summary;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   task automatic t_reset;
      chk("R1", "m_req", 32'(m_req), 0);
      chk("R1", "xfer_busy", 32'(xfer_busy), 0);
      chk("R1", "per_done", 32'(per_done), 0);
      chk("R1", "ch_end", 32'(ch_end), 32'h3F_FFFF);
      chk("R1", "ch_full", 32'(ch_full), 32'h3F_FFFF);
   endtask

   task automatic t_rx_basic;
      int b;
      b = ln;
      setup(12, 32'h1000, 3, 32'h1);
      per_req[12] = 1'b1;
      cycles(40);
      per_req[12] = 1'b0;
      chk("R2", "rx count", 32'(ln - b), 3);
      for (int k = 0; k < 3; k++) begin
         chk("R2", "rx addr", la[b+k], 32'h1000 + 32'(4*k));
         chk("R3", "rx we", 32'(lw[b+k]), 1);
         chk("R3", "rx data", ld[b+k], 32'h5A00_000C);
      end
      chk("R8", "rx ch_full after drain", 32'(ch_full[12]), 1);
      chk("R8", "rx ch_end after drain", 32'(ch_end[12]), 1);
   endtask

   task automatic t_tx_basic;
      int b, d;
      b = ln; d = dn;
      mem_lat = 2;
      setup(3, 32'h2000, 2, 32'h1);
      per_req[3] = 1'b1;
      cycles(40);
      per_req[3] = 1'b0;
      chk("R2", "tx count", 32'(ln - b), 2);
      chk("R6", "tx done count", 32'(dn - d), 2);
      for (int k = 0; k < 2; k++) begin
         chk("R2", "tx addr", la[b+k], 32'h2000 + 32'(4*k));
         chk("R3", "tx we", 32'(lw[b+k]), 0);
         chk("R6", "tx done channel", 32'(dc[d+k]), 3);
         chk("R3", "tx word", dt[d+k], (32'h2000 + 32'(4*k)) ^ KEY);
      end
      mem_lat = 0;
   endtask

   task automatic t_priority;
      int b;
      b = ln;
      setup(0, 32'hA000, 1, 32'h1);
      setup(9, 32'hA100, 1, 32'h1);
      setup(10, 32'hA200, 1, 32'h1);
      setup(21, 32'hA300, 1, 32'h1);
      cycles(5);
      chk("R4", "no request no transfer", 32'(ln - b), 0);
      @(negedge clk);
      per_req = per_req | 22'h200601;
      cycles(40);
      per_req = '0;
      chk("R4", "prio count", 32'(ln - b), 4);
      chk("R4", "first", 32'(lc[b]), 21);
      chk("R4", "second", 32'(lc[b+1]), 10);
      chk("R4", "third", 32'(lc[b+2]), 9);
      chk("R4", "fourth", 32'(lc[b+3]), 0);
      chk("R11", "shared default tx", 32'(lw[b]), 0);
   endtask

   task automatic t_reload;
      int b;
      b = ln;
      setup(15, 32'h3000, 2, 32'h0);
      wr(15, 3'd2, 32'h4000);
      wr(15, 3'd3, 2);
      cycles(2);
      chk("R8", "queued not full", 32'(ch_full[15]), 0);
      wr(15, 3'd4, 32'h1);
      per_req[15] = 1'b1;
      cycles(60);
      per_req[15] = 1'b0;
      chk("R7", "chain count", 32'(ln - b), 4);
      chk("R7", "chain a0", la[b], 32'h3000);
      chk("R7", "chain a1", la[b+1], 32'h3004);
      chk("R7", "chain a2", la[b+2], 32'h4000);
      chk("R7", "chain a3", la[b+3], 32'h4004);
      chk("R7", "chain drained", 32'(ch_full[15]), 1);
      // reload into an empty current buffer
      b = ln;
      wr(16, 3'd2, 32'h5000);
      wr(16, 3'd3, 1);
      cycles(2);
      chk("R7", "empty reload end", 32'(ch_end[16]), 0);
      wr(16, 3'd4, 32'h1);
      per_req[16] = 1'b1;
      cycles(20);
      per_req[16] = 1'b0;
      chk("R7", "empty reload count", 32'(ln - b), 1);
      chk("R7", "empty reload addr", la[b], 32'h5000);
      // drained channel that keeps requesting
      b = ln;
      per_req[16] = 1'b1;
      cycles(15);
      per_req[16] = 1'b0;
      chk("R8", "drained ignored", 32'(ln - b), 0);
   endtask

   task automatic t_disable;
      int b;
      b = ln;
      mem_lat = 3;
      setup(11, 32'h6000, 4, 32'h0);
      per_req[11] = 1'b1;
      cycles(20);
      chk("R9", "disabled not served", 32'(ln - b), 0);
      wr(11, 3'd4, 32'h1);
      wait (ln == b + 1);
      wr(11, 3'd4, 32'h2);
      cycles(30);
      chk("R9", "stopped after disable", 32'(ln - b), 1);
      chk("R9", "words kept", 32'(ch_end[11]), 0);
      wr(11, 3'd4, 32'h3);
      cycles(30);
      chk("R9", "both bits disable", 32'(ln - b), 1);
      wr(11, 3'd4, 32'h1);
      cycles(60);
      per_req[11] = 1'b0;
      chk("R9", "resume count", 32'(ln - b), 4);
      chk("R9", "resume a1", la[b+1], 32'h6004);
      chk("R9", "resume a3", la[b+3], 32'h600C);
      mem_lat = 0;
   endtask

   task automatic t_shared_dir;
      int b;
      b = ln;
      setup(21, 32'h8000, 1, 32'h5);
      setup(5, 32'h9000, 1, 32'h5);
      @(negedge clk);
      per_req[21] = 1'b1; per_req[5] = 1'b1;
      cycles(30);
      per_req = '0;
      chk("R11", "dir count", 32'(ln - b), 2);
      chk("R11", "shared rx write", 32'(lw[b]), 1);
      chk("R11", "shared rx data", ld[b], 32'h5A00_0015);
      chk("R11", "fixed tx ignores bit", 32'(lw[b+1]), 0);
      chk("R11", "fixed tx addr", la[b+1], 32'h9000);
   endtask

   task automatic t_deferred;
      int b;
      b = ln;
      mem_lat = 6;
      setup(13, 32'h7000, 1, 32'h1);
      per_req[13] = 1'b1;
      wait (m_req && xfer_ch == 5'd13);
      wr(13, 3'd1, 3);
      cycles(80);
      per_req[13] = 1'b0;
      chk("R10", "deferred count", 32'(ln - b), 4);
      chk("R10", "deferred a1", la[b+1], 32'h7004);
      chk("R10", "deferred a3", la[b+3], 32'h700C);
      mem_lat = 0;
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
   end

   initial begin
      cycles(3);
      rst_n = 1'b1;
      cycles(2);
      t_reset();
      t_rx_basic();
      t_tx_basic();
      t_priority();
      t_reload();
      t_disable();
      t_shared_dir();
      t_deferred();
      chk("R5", "handshake violations", 32'(r5_err), 0);
      chk("R6", "done pulse violations", 32'(r6_err), 0);
      summary();
   end
endmodule